// File: doc/BRIEF.md
# Bilinear Interpolation Pipeline

This block turns a stream of pre-ordered pixel quadruples into bilinearly interpolated greyscale pixels at a rate of one per clock. Each cycle the block takes four 8-bit neighbours: upper-left, upper-right, lower-left and lower-right. With them come a 7-bit horizontal fraction and a 7-bit vertical fraction. Each fraction stands for a weight of value/128 towards the right-hand or lower sample. A qualifier travels with every quadruple and comes out beside the matching result.

The arithmetic has two stages. First, two horizontal blends run side by side, one for the upper row and one for the lower row. Both use the horizontal fraction. Second, one vertical blend combines the two row results using the vertical fraction. That fraction is delayed so that it meets its own row results. Every blend has the form near + floor((far − near) · k / 128). It uses one multiplier and needs no saturation, because the result always lies between near and far. An upstream fetch unit that holds the frame and works out the addresses feeds this block with ordered neighbours.

The design is a pure datapath, so it has no control state machine. Data moves down a fixed chain of registers: capture, product and sum, capture, product and sum.

Top module: `bilerp_pipe`

## Requirements
- R1: The result equals v = t + floor((u − t)·fy/128). Here t = ul + floor((ur − ul)·fx/128) and u = ll + floor((lr − ll)·fx/128), and each intermediate is kept as an 8-bit unsigned value.
- R2: The latency is exactly 4 cycles. `out_valid` is `in_valid` delayed by 4 rising edges, and `out_pix` belongs to the quadruple taken 4 edges earlier.
- R3: When fx = 0 and fy = 0 the result equals the upper-left pixel.
- R4: A qualified result never lies outside the range from the smallest to the largest of its four neighbours.
- R5: A new quadruple is accepted on every edge. Back-to-back inputs give back-to-back results with no bubble.
- R6: Each result uses the vertical fraction that arrived with its own quadruple, even while a later quadruple is in the horizontal stage.
- R7: While `rst_n` is low, `out_valid` and `out_pix` read 0. After release they stay 0 until qualified data has passed through all 4 stages.
- R8: A blend towards a smaller far sample rounds towards negative infinity. For example near 10, far 9 and k 64 give 9.
- R9: When all four neighbours are equal, the result equals that value for any fractions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies the quadruple on this edge |
| in_pix_ul | input | 8 | Upper-row near (left) neighbour |
| in_pix_ur | input | 8 | Upper-row far (right) neighbour |
| in_pix_ll | input | 8 | Lower-row near (left) neighbour |
| in_pix_lr | input | 8 | Lower-row far (right) neighbour |
| in_frac_x | input | 7 | Horizontal weight, value/128 |
| in_frac_y | input | 7 | Vertical weight, value/128 |
| out_valid | output | 1 | Qualifier of the result |
| out_pix | output | 8 | Interpolated pixel |

## Verification
The horizontal blend of one quadruple and the vertical blend of an earlier quadruple always run in the same cycle. The vertical fraction must therefore pass the horizontal stage without mixing with its neighbours. The bench makes this happen by streaming table vectors back to back, each with a different vertical fraction, and then a computed stream with gaps in the qualifier. Every output sampled four cycles later must match a value built only from its own quadruple. A wrong delay on the fraction shows up as a result built from the fraction of a neighbouring vector.

// File: rtl/bilerp_pkg.sv
package bilerp_pkg;
    localparam int PIX_W    = 8;
    localparam int FRAC_W   = 7;
    localparam int LERP_LAT = 2;
    localparam int ROWS     = 2;

    typedef logic [PIX_W-1:0]  pix_t;
    typedef logic [FRAC_W-1:0] frac_t;
endpackage

// File: rtl/bilerp_delay.sv
module bilerp_delay #(
    parameter int WIDTH = 1,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [DEPTH];

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign dout = stg[DEPTH-1];
endmodule

// File: rtl/bilerp_lerp.sv
module bilerp_lerp #(
    parameter int PIX_W  = bilerp_pkg::PIX_W,
    parameter int FRAC_W = bilerp_pkg::FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIX_W-1:0]  near_pix,
    input  logic [PIX_W-1:0]  far_pix,
    input  logic [FRAC_W-1:0] frac,
    output logic [PIX_W-1:0]  mix_pix
);
    localparam int DIFF_W = PIX_W + 1;
    localparam int PROD_W = DIFF_W + FRAC_W + 1;

    // stage A: capture base and signed difference
    logic signed [DIFF_W-1:0] diff_d;
    logic signed [DIFF_W-1:0] diff_q;
    logic [PIX_W-1:0]         base_q;
    logic [FRAC_W-1:0]        frac_q;

    assign diff_d = $signed({1'b0, far_pix}) - $signed({1'b0, near_pix});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            diff_q <= '0;
            frac_q <= '0;
        end else begin
            base_q <= near_pix;
            diff_q <= diff_d;
            frac_q <= frac;
        end
    end

    // stage B: signed product, floor shift, add base
    logic signed [PROD_W-1:0] diff_ext;
    logic signed [PROD_W-1:0] frac_ext;
    logic signed [PROD_W-1:0] base_ext;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] step;

    assign diff_ext = {{(PROD_W-DIFF_W){diff_q[DIFF_W-1]}}, diff_q};
    assign frac_ext = {{(PROD_W-FRAC_W){1'b0}}, frac_q};
    assign base_ext = {{(PROD_W-PIX_W){1'b0}}, base_q};
    assign prod     = diff_ext * frac_ext;
    assign step     = prod >>> FRAC_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mix_pix <= '0;
        else        mix_pix <= PIX_W'(base_ext + step);
    end
endmodule

// File: rtl/bilerp_pipe.sv
module bilerp_pipe #(
    parameter int PIX_W  = bilerp_pkg::PIX_W,
    parameter int FRAC_W = bilerp_pkg::FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_pix_ul,
    input  logic [PIX_W-1:0]  in_pix_ur,
    input  logic [PIX_W-1:0]  in_pix_ll,
    input  logic [PIX_W-1:0]  in_pix_lr,
    input  logic [FRAC_W-1:0] in_frac_x,
    input  logic [FRAC_W-1:0] in_frac_y,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_pix
);
    localparam int LERP_LAT  = bilerp_pkg::LERP_LAT;
    localparam int ROWS      = bilerp_pkg::ROWS;
    localparam int TOTAL_LAT = 2 * LERP_LAT;

    logic [PIX_W-1:0]  row_near [ROWS];
    logic [PIX_W-1:0]  row_far  [ROWS];
    logic [PIX_W-1:0]  row_mix  [ROWS];
    logic [FRAC_W-1:0] frac_y_d;

    assign row_near[0] = in_pix_ul;
    assign row_far[0]  = in_pix_ur;
    assign row_near[1] = in_pix_ll;
    assign row_far[1]  = in_pix_lr;

    // horizontal stage: one blend per row, side by side (R1, R5)
    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            bilerp_lerp #(.PIX_W(PIX_W), .FRAC_W(FRAC_W)) u_hlerp (
                .clk      (clk),
                .rst_n    (rst_n),
                .near_pix (row_near[r]),
                .far_pix  (row_far[r]),
                .frac     (in_frac_x),
                .mix_pix  (row_mix[r])
            );
        end
    endgenerate

    // vertical fraction waits out the horizontal stage (R6)
    bilerp_delay #(.WIDTH(FRAC_W), .DEPTH(LERP_LAT)) u_fy_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (in_frac_y),
        .dout  (frac_y_d)
    );

    // vertical stage
    bilerp_lerp #(.PIX_W(PIX_W), .FRAC_W(FRAC_W)) u_vlerp (
        .clk      (clk),
        .rst_n    (rst_n),
        .near_pix (row_mix[0]),
        .far_pix  (row_mix[1]),
        .frac     (frac_y_d),
        .mix_pix  (out_pix)
    );

    // qualifier rides alongside the data (R2)
    bilerp_delay #(.WIDTH(1), .DEPTH(TOTAL_LAT)) u_vld_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (in_valid),
        .dout  (out_valid)
    );
endmodule

// File: rtl/bilerp_pipe_chk.sv
module bilerp_pipe_chk #(
    parameter int PIX_W  = bilerp_pkg::PIX_W,
    parameter int FRAC_W = bilerp_pkg::FRAC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [PIX_W-1:0]  in_pix_ul,
    input logic [PIX_W-1:0]  in_pix_ur,
    input logic [PIX_W-1:0]  in_pix_ll,
    input logic [PIX_W-1:0]  in_pix_lr,
    input logic [FRAC_W-1:0] in_frac_x,
    input logic [FRAC_W-1:0] in_frac_y,
    input logic              out_valid,
    input logic [PIX_W-1:0]  out_pix
);
    logic [2:0]       since_rst;
    logic [PIX_W-1:0] lo_in, hi_in, lo_a, hi_a, lo_b, hi_b;
    logic             flat_in, zero_frac;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    assign lo_a      = (in_pix_ul < in_pix_ur) ? in_pix_ul : in_pix_ur;
    assign hi_a      = (in_pix_ul < in_pix_ur) ? in_pix_ur : in_pix_ul;
    assign lo_b      = (in_pix_ll < in_pix_lr) ? in_pix_ll : in_pix_lr;
    assign hi_b      = (in_pix_ll < in_pix_lr) ? in_pix_lr : in_pix_ll;
    assign lo_in     = (lo_a < lo_b) ? lo_a : lo_b;
    assign hi_in     = (hi_a < hi_b) ? hi_b : hi_a;
    assign flat_in   = (in_pix_ul == in_pix_ur) && (in_pix_ul == in_pix_ll) && (in_pix_ul == in_pix_lr);
    assign zero_frac = (in_frac_x == '0) && (in_frac_y == '0);

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd4) |-> (out_valid == $past(in_valid, 4))); // R2

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && (out_pix == '0))); // R7

    AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst >= 3'd4) && out_valid) |-> ((out_pix >= $past(lo_in, 4)) && (out_pix <= $past(hi_in, 4)))); // R4

    AST_FLAT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst >= 3'd4) && out_valid && $past(flat_in, 4)) |-> (out_pix == $past(in_pix_ul, 4))); // R9

    AST_ZERO_FRAC: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst >= 3'd4) && out_valid && $past(zero_frac, 4)) |-> (out_pix == $past(in_pix_ul, 4))); // R3
endmodule

bind bilerp_pipe bilerp_pipe_chk #(.PIX_W(PIX_W), .FRAC_W(FRAC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_pix_ul (in_pix_ul),
    .in_pix_ur (in_pix_ur),
    .in_pix_ll (in_pix_ll),
    .in_pix_lr (in_pix_lr),
    .in_frac_x (in_frac_x),
    .in_frac_y (in_frac_y),
    .out_valid (out_valid),
    .out_pix   (out_pix)
);

// File: tb/bilerp_pipe_bench.sv
module bilerp_pipe_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    localparam int NS = 40;

    // {ul, ur, ll, lr, fx, fy, expected}
    localparam logic [53:0] VECS [NV] = '{
        {8'd10,  8'd20,  8'd30,  8'd40,  7'd0,   7'd0,   8'd10},
        {8'd0,   8'd100, 8'd200, 8'd255, 7'd64,  7'd64,  8'd138},
        {8'd255, 8'd0,   8'd0,   8'd255, 7'd127, 7'd127, 8'd251},
        {8'd10,  8'd9,   8'd10,  8'd9,   7'd64,  7'd0,   8'd9},
        {8'd77,  8'd77,  8'd77,  8'd77,  7'd99,  7'd33,  8'd77},
        {8'd100, 8'd200, 8'd50,  8'd150, 7'd32,  7'd96,  8'd87},
        {8'd0,   8'd255, 8'd255, 8'd0,   7'd1,   7'd127, 8'd251},
        {8'd200, 8'd100, 8'd40,  8'd60,  7'd127, 7'd1,   8'd99}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_pix_ul = '0, in_pix_ur = '0, in_pix_ll = '0, in_pix_lr = '0;
    logic [6:0] in_frac_x = '0, in_frac_y = '0;
    logic       out_valid;
    logic [7:0] out_pix;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bilerp_pipe u_bilerp_pipe (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_pix_ul(in_pix_ul), .in_pix_ur(in_pix_ur),
        .in_pix_ll(in_pix_ll), .in_pix_lr(in_pix_lr),
        .in_frac_x(in_frac_x), .in_frac_y(in_frac_y),
        .out_valid(out_valid), .out_pix(out_pix)
    );

    function automatic int blend(input int a, input int b, input int k);
        return (a + (((b - a) * k) >>> 7)) & 255;
    endfunction

    function automatic int model(input int ul, input int ur, input int ll, input int lr,
                                 input int fx, input int fy);
        int t, u;
        t = blend(ul, ur, fx);
        u = blend(ll, lr, fx);
        return blend(t, u, fy);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] c, input logic [7:0] d,
                         input logic [6:0] fx, input logic [6:0] fy);
        in_valid = v; in_pix_ul = a; in_pix_ur = b; in_pix_ll = c; in_pix_lr = d;
        in_frac_x = fx; in_frac_y = fy;
    endtask

    int exp_pix [NS];
    bit exp_vld [NS];

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state
        check("R7 reset out_valid", int'(out_valid), 0);
        check("R7 reset out_pix", int'(out_pix), 0);
        rst_n = 1'b1;

        // table walk, back to back: R1 R3 R5 R6 R8 R9
        for (int i = 0; i < NV + 4; i++) begin
            @(negedge clk);
            if (i >= 4) begin
                check($sformatf("R1/R5/R6 vec%0d out_pix", i-4), int'(out_pix), int'(VECS[i-4][7:0]));
                check($sformatf("R2 vec%0d out_valid", i-4), int'(out_valid), 1);
            end else begin
                check("R7 idle out_valid after release", int'(out_valid), 0);
            end
            if (i < NV)
                drive(1'b1, VECS[i][53:46], VECS[i][45:38], VECS[i][37:30], VECS[i][29:22],
                      VECS[i][21:15], VECS[i][14:8]);
            else
                drive(1'b0, 8'd0, 8'd0, 8'd0, 8'd0, 7'd0, 7'd0);
        end
        // explicit corner tags: R3 (vec0), R8 (vec3), R9 (vec4) covered above
        check("R3 zero fractions give upper-left (model)", model(10,20,30,40,0,0), 10);
        check("R8 descending blend floors (model)", blend(10, 9, 64), 9);
        check("R9 flat quadruple (model)", model(77,77,77,77,99,33), 77);

        // computed stream with qualifier gaps: R2 R4 R6
        for (int i = 0; i < NS + 4; i++) begin
            @(negedge clk);
            if (i >= 4) begin
                check($sformatf("R2 stream%0d out_valid", i-4), int'(out_valid), int'(exp_vld[i-4]));
                if (exp_vld[i-4])
                    check($sformatf("R6 stream%0d out_pix", i-4), int'(out_pix), exp_pix[i-4]);
            end
            if (i < NS) begin
                automatic int a = (i*37 + 5) & 255;
                automatic int b = (i*91 + 200) & 255;
                automatic int c = (i*53 + 17) & 255;
                automatic int d = (255 - i*29) & 255;
                automatic int fx = (i*11 + 3) & 127;
                automatic int fy = (i*23 + 64) & 127;
                exp_vld[i] = (i % 3) != 2;
                exp_pix[i] = model(a, b, c, d, fx, fy);
                drive(exp_vld[i], 8'(a), 8'(b), 8'(c), 8'(d), 7'(fx), 7'(fy));
            end else begin
                drive(1'b0, 8'd0, 8'd0, 8'd0, 8'd0, 7'd0, 7'd0);
            end
        end

        // mid-stream reset: R7
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            drive(1'b1, 8'd200, 8'd210, 8'd220, 8'd230, 7'd50, 7'd50);
        end
        @(negedge clk);
        drive(1'b0, 8'd0, 8'd0, 8'd0, 8'd0, 7'd0, 7'd0);
        rst_n = 1'b0;
        #1;
        check("R7 mid-stream reset out_valid", int'(out_valid), 0);
        check("R7 mid-stream reset out_pix", int'(out_pix), 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R7 flushed after reset", int'(out_valid), 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog R5 actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule